// File: doc/BRIEF.md
# Real-Time Clock Counter with Alarm and Interrupt Flags

This block keeps the time of day as three separate counters: a 16-bit day count, an hour/minute word and a seconds value. An external prescaler supplies a once-per-second strobe, a twice-per-second strobe and eight faster sampling strobes. While the run bit of the control register is set, each once-per-second strobe advances the time by one second, with carries through minutes, hours and days. After each advance the new time is compared against a programmable day/hour/minute/second alarm.

Every strobe source and the alarm match has its own flag in an interrupt status register. Software clears these flags by writing ones. A separate enable register selects which flags drive the single level-sensitive interrupt line. Software reaches all state through a plain 16-bit register port. Writes take effect on the clock edge. Reads are combinational from the address. The port has no handshake, because every access completes in one cycle.

Top module: `rtc_core`

## Requirements
- R1: After reset, the time, alarm, control, status and enable registers all read 0, and `irq_o` is low.
- R2: The register offsets are 0x00 hour/minute, 0x04 seconds, 0x08 alarm hour/minute, 0x0C alarm seconds, 0x10 control, 0x14 status, 0x18 enable, 0x20 day and 0x24 alarm day. Hour/minute words carry the hour in bits 15:8 and the minute in bits 7:0. A write loads the register directly, and reading it back returns the written in-range value.
- R3: While control bit 7 (run) is set, each pulse of `tick_1hz_i` adds one second. While run is clear, the time holds.
- R4: Seconds wrap from 59 to 0 with a carry into minutes. Minutes wrap from 59 to 0 with a carry into hours. Hours wrap from 23 to 0 with a carry into the day count.
- R5: The day count is 16 bits wide and wraps from 0xFFFF to 0.
- R6: Status flags are set by these sources: bit 4 by `tick_1hz_i`, bit 7 by `tick_2hz_i`, and bits 8+i by `tick_samp_i[i]` for i in 0..7. Bit 0 (stopwatch placeholder) is never set by hardware. Unused bits 1, 3, 5 and 6 read 0.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: A status bit whose source fires in the same cycle as a clearing write remains set.
- R9: `irq_o` is high exactly when some status bit and the enable bit at the same position are both set.
- R10: Status bit 2 (alarm) sets when the time produced by a one-second advance equals the alarm day, hour, minute and second. Loading the time to the alarm value does not set it. Strobes that arrive while the time is held do not set it.
- R11: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R12: In a cycle that writes any time register, the one-second advance is dropped, and the written field takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_1hz_i | input | 1 | One-cycle strobe, once per second |
| tick_2hz_i | input | 1 | One-cycle strobe, twice per second |
| tick_samp_i | input | 8 | Sampling strobes, 4 Hz (bit 0) up to 512 Hz (bit 7) |
| reg_addr_i | input | 6 | Register byte offset |
| reg_we_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The counters are run through two long stretches. The first starts at midnight and covers more than an hour, which exercises every second and minute carry and one hour carry. The second starts shortly before midnight on a mid-range day and shows that the hour carries into the day count. A short run from day 0xFFFF isolates the day wrap. Each strobe source is pulsed on its own, so a wrong bit position shows up at once. For each flag, the interrupt line is checked with only its own enable set and again with every other enable set, which separates a correct mask from an OR of all flags. For the alarm, the bench compares three cases at the same time value: reached by counting, loaded by a write, and held while strobes arrive. Only the first case may raise the flag.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DAY_W  = 16;
  localparam int HR_W   = 5;
  localparam int MIN_W  = 6;
  localparam int SEC_W  = 6;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int SAMP_N = 8;

  localparam logic [ADDR_W-1:0] OFS_HRMIN  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SEC    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_AHRMIN = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_ASEC   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_DAY    = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ADAY   = 6'h24;

  localparam int BIT_SW    = 0;
  localparam int BIT_ALM   = 2;
  localparam int BIT_1HZ   = 4;
  localparam int BIT_2HZ   = 7;
  localparam int BIT_SAMP0 = 8;
  localparam int CTRL_RUN  = 7;

  localparam int HR_LSB = 8;

  localparam logic [DATA_W-1:0] STAT_IMPL =
      (16'hFF << BIT_SAMP0) | (16'h1 << BIT_2HZ) | (16'h1 << BIT_1HZ) |
      (16'h1 << BIT_ALM) | (16'h1 << BIT_SW);

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sc;
  } rtc_time_t;
endpackage

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              ld_hm_i,
  input  logic              ld_sec_i,
  input  logic              ld_day_i,
  input  logic [DATA_W-1:0] wdata_i,
  output rtc_time_t         now_o,
  output rtc_time_t         nxt_o,
  output logic              step_o
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);

  rtc_time_t cur_q, nxt;
  logic      any_ld;

  always_comb begin
    nxt = cur_q;
    if (cur_q.sc >= SEC_LAST) begin
      nxt.sc = '0;
      if (cur_q.mn >= MIN_LAST) begin
        nxt.mn = '0;
        if (cur_q.hr >= HR_LAST) begin
          nxt.hr  = '0;
          nxt.day = cur_q.day + DAY_W'(1);
        end else begin
          nxt.hr = cur_q.hr + HR_W'(1);
        end
      end else begin
        nxt.mn = cur_q.mn + MIN_W'(1);
      end
    end else begin
      nxt.sc = cur_q.sc + SEC_W'(1);
    end
  end

  assign any_ld = ld_hm_i | ld_sec_i | ld_day_i;
  assign step_o = adv_i & ~any_ld;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (any_ld) begin
      if (ld_hm_i) begin
        cur_q.hr <= wdata_i[HR_LSB +: HR_W];
        cur_q.mn <= wdata_i[0 +: MIN_W];
      end
      if (ld_sec_i) cur_q.sc  <= wdata_i[0 +: SEC_W];
      if (ld_day_i) cur_q.day <= wdata_i[0 +: DAY_W];
    end else if (step_o) begin
      cur_q <= nxt;
    end
  end

  assign now_o = cur_q;
  assign nxt_o = nxt;

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cur_q.sc == SEC_LAST) |=> (cur_q.sc == '0)); // R4
  AST_DAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cur_q.sc == SEC_LAST && cur_q.mn == MIN_LAST &&
     cur_q.hr == HR_LAST && (&cur_q.day)) |=> (cur_q.day == '0)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_sec_i |=> (cur_q.sc == $past(wdata_i[0 +: SEC_W]))); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !any_ld) |=> $stable(cur_q)); // R3
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_hm_i,
  input  logic              ld_sec_i,
  input  logic              ld_day_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              step_i,
  input  rtc_time_t         nxt_i,
  output rtc_time_t         alm_o,
  output logic              hit_o
);
  rtc_time_t alm_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      alm_q <= '0;
    end else begin
      if (ld_hm_i) begin
        alm_q.hr <= wdata_i[HR_LSB +: HR_W];
        alm_q.mn <= wdata_i[0 +: MIN_W];
      end
      if (ld_sec_i) alm_q.sc  <= wdata_i[0 +: SEC_W];
      if (ld_day_i) alm_q.day <= wdata_i[0 +: DAY_W];
    end
  end

  assign hit_o = step_i && (nxt_i == alm_q);
  assign alm_o = alm_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic              clr_en_i,
  input  logic              ien_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] ien_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] stat_q, ien_q, clr_mask;

  assign clr_mask = clr_en_i ? wdata_i : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | (set_i & STAT_IMPL);
      if (ien_wr_i) ien_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign irq_o  = |(stat_q & ien_q);

  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((stat_q & $past(wdata_i & ~set_i)) == '0)); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_en_i && set_i == '0) |=> $stable(stat_q)); // R7
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_1hz_i,
  input  logic              tick_2hz_i,
  input  logic [SAMP_N-1:0] tick_samp_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  rtc_time_t         now, nxt, alm;
  logic              step, hit;
  logic [DATA_W-1:0] ctrl_q, stat, ien, set_vec;
  logic              run;

  logic we_hm, we_sec, we_day, we_ahm, we_asec, we_aday, we_ctrl, we_stat, we_ien;
  assign we_hm   = reg_we_i && reg_addr_i == OFS_HRMIN;
  assign we_sec  = reg_we_i && reg_addr_i == OFS_SEC;
  assign we_day  = reg_we_i && reg_addr_i == OFS_DAY;
  assign we_ahm  = reg_we_i && reg_addr_i == OFS_AHRMIN;
  assign we_asec = reg_we_i && reg_addr_i == OFS_ASEC;
  assign we_aday = reg_we_i && reg_addr_i == OFS_ADAY;
  assign we_ctrl = reg_we_i && reg_addr_i == OFS_CTRL;
  assign we_stat = reg_we_i && reg_addr_i == OFS_STAT;
  assign we_ien  = reg_we_i && reg_addr_i == OFS_IEN;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (we_ctrl) ctrl_q <= reg_wdata_i;
  end
  assign run = ctrl_q[CTRL_RUN];

  rtc_time_cnt u_time (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(tick_1hz_i & run),
    .ld_hm_i(we_hm), .ld_sec_i(we_sec), .ld_day_i(we_day),
    .wdata_i(reg_wdata_i), .now_o(now), .nxt_o(nxt), .step_o(step)
  );

  rtc_alarm_cmp u_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_hm_i(we_ahm), .ld_sec_i(we_asec), .ld_day_i(we_aday),
    .wdata_i(reg_wdata_i), .step_i(step), .nxt_i(nxt),
    .alm_o(alm), .hit_o(hit)
  );

  assign set_vec[BIT_SW]        = 1'b0;
  assign set_vec[1]             = 1'b0;
  assign set_vec[BIT_ALM]       = hit;
  assign set_vec[3]             = 1'b0;
  assign set_vec[BIT_1HZ]       = tick_1hz_i;
  assign set_vec[6:5]           = 2'b00;
  assign set_vec[BIT_2HZ]       = tick_2hz_i;
  for (genvar g = 0; g < SAMP_N; g++) begin : g_samp
    assign set_vec[BIT_SAMP0 + g] = tick_samp_i[g];
  end

  rtc_irq_ctrl u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec),
    .clr_en_i(we_stat), .ien_wr_i(we_ien), .wdata_i(reg_wdata_i),
    .stat_o(stat), .ien_o(ien), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_HRMIN:  reg_rdata_o = {(DATA_W-HR_LSB)'(now.hr), HR_LSB'(now.mn)};
      OFS_SEC:    reg_rdata_o = DATA_W'(now.sc);
      OFS_DAY:    reg_rdata_o = DATA_W'(now.day);
      OFS_AHRMIN: reg_rdata_o = {(DATA_W-HR_LSB)'(alm.hr), HR_LSB'(alm.mn)};
      OFS_ASEC:   reg_rdata_o = DATA_W'(alm.sc);
      OFS_ADAY:   reg_rdata_o = DATA_W'(alm.day);
      OFS_CTRL:   reg_rdata_o = ctrl_q;
      OFS_STAT:   reg_rdata_o = stat;
      OFS_IEN:    reg_rdata_o = ien;
      default:    reg_rdata_o = '0;
    endcase
  end

  AST_ALARM_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> stat[BIT_ALM]); // R10
  AST_NO_ALARM_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !stat[BIT_ALM] && !we_stat) |=> !stat[BIT_ALM]); // R10
endmodule

// File: tb/rtc_core_bench.sv
`timescale 1ns/1ps
module rtc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        t1 = 1'b0, t2 = 1'b0;
  logic [7:0]  ts = '0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_core u_rtc_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(t1), .tick_2hz_i(t2),
    .tick_samp_i(ts), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [5:0] a, input logic [15:0] d,
                     input logic s1, input logic s2, input logic [7:0] sm);
    @(negedge clk);
    we = w; addr = a; wd = d; t1 = s1; t2 = s2; ts = sm;
    @(negedge clk);
    we = 1'b0; t1 = 1'b0; t2 = 1'b0; ts = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic rdr(input logic [5:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd;
  endtask

  task automatic tick1();
    cyc(1'b0, 6'h3F, 16'h0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic set_time(input longint t);
    longint r;
    r = t % 86400;
    wr(6'h20, 16'((t / 86400) % 65536));
    wr(6'h00, {8'(r / 3600), 8'((r % 3600) / 60)});
    wr(6'h04, 16'(r % 60));
  endtask

  task automatic chk_time(input string tag, input longint t);
    logic [15:0] v;
    longint r;
    r = t % 86400;
    rdr(6'h04, v); chk({tag, " sec"}, v, 16'(r % 60));
    rdr(6'h00, v); chk({tag, " hrmin"}, v, {8'(r / 3600), 8'((r % 3600) / 60)});
    rdr(6'h20, v); chk({tag, " day"}, v, 16'((t / 86400) % 65536));
  endtask

  task automatic sweep(input string tag, input longint t0, input int n);
    longint t;
    t = t0;
    wr(6'h10, 16'h0000);
    set_time(t);
    wr(6'h10, 16'h0080);
    for (int i = 0; i < n; i++) begin
      tick1();
      t++;
      chk_time(tag, t);
    end
    wr(6'h10, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    logic [5:0] regs [9];
    regs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (regs[k]) begin
      rdr(regs[k], v); chk("R1 reset reg", v, 16'h0);
    end
    chk("R1 reset irq", {15'h0, irq}, 16'h0);

    // R2 readback through the map
    wr(6'h00, 16'h1734); rdr(6'h00, v); chk("R2 hrmin", v, 16'h1734);
    wr(6'h04, 16'h002A); rdr(6'h04, v); chk("R2 sec", v, 16'h002A);
    wr(6'h20, 16'hBEEF); rdr(6'h20, v); chk("R2 day", v, 16'hBEEF);
    wr(6'h08, 16'h0A14); rdr(6'h08, v); chk("R2 alarm hrmin", v, 16'h0A14);
    wr(6'h0C, 16'h001E); rdr(6'h0C, v); chk("R2 alarm sec", v, 16'h001E);
    wr(6'h24, 16'h0003); rdr(6'h24, v); chk("R2 alarm day", v, 16'h0003);
    wr(6'h10, 16'h0020); rdr(6'h10, v); chk("R2 ctrl", v, 16'h0020);
    wr(6'h18, 16'h5A5A); rdr(6'h18, v); chk("R2 enable", v, 16'h5A5A);
    wr(6'h18, 16'h0000);

    // R11 unmapped offsets
    wr(6'h1C, 16'hFFFF); rdr(6'h1C, v); chk("R11 read 1C", v, 16'h0);
    wr(6'h28, 16'hFFFF); rdr(6'h28, v); chk("R11 read 28", v, 16'h0);
    wr(6'h3C, 16'hFFFF);
    rdr(6'h00, v); chk("R11 hrmin intact", v, 16'h1734);
    rdr(6'h20, v); chk("R11 day intact", v, 16'hBEEF);
    rdr(6'h14, v); chk("R11 status intact", v, 16'h0);

    // R3 held when run is clear
    tick1(); rdr(6'h04, v); chk("R3 held sec", v, 16'h002A);
    wr(6'h14, 16'hFFFF);

    // R3 R4 long sweep from midnight, R4 across day carry, R5 day wrap
    sweep("R4 sweep0", 64'd0, 3700);
    sweep("R4 sweep5", 64'd5 * 86400 + 23 * 3600 + 58 * 60, 150);
    sweep("R5 wrap", 64'd65535 * 86400 + 86395, 10);

    // R12 write in the same cycle as an advance
    set_time(64'd1 * 86400 + 3600 + 120 + 10);
    wr(6'h10, 16'h0080);
    cyc(1'b1, 6'h04, 16'd40, 1'b1, 1'b0, 8'h00);
    rdr(6'h04, v); chk("R12 sec written", v, 16'd40);
    rdr(6'h00, v); chk("R12 hrmin kept", v, 16'h0102);
    wr(6'h10, 16'h0000);

    // R6 sources and positions
    wr(6'h14, 16'hFFFF);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 6'h3F, 16'h0, 1'b0, 1'b0, 8'(1 << i));
      rdr(6'h14, v); chk("R6 samp bit", v, 16'(1 << (8 + i)));
      wr(6'h14, 16'hFFFF);
    end
    cyc(1'b0, 6'h3F, 16'h0, 1'b0, 1'b1, 8'h00);
    rdr(6'h14, v); chk("R6 2hz bit", v, 16'h0080);
    wr(6'h14, 16'hFFFF);
    tick1(); rdr(6'h14, v); chk("R6 1hz bit", v, 16'h0010);
    wr(6'h14, 16'hFFFF);

    // R7 write-one-to-clear
    cyc(1'b0, 6'h3F, 16'h0, 1'b1, 1'b1, 8'h81);
    rdr(6'h14, v); chk("R7 set", v, 16'h8190);
    wr(6'h14, 16'h0000); rdr(6'h14, v); chk("R7 zero no effect", v, 16'h8190);
    wr(6'h14, 16'h0110); rdr(6'h14, v); chk("R7 partial clear", v, 16'h8080);
    wr(6'h14, v);        rdr(6'h14, v); chk("R7 read-back clear", v, 16'h0000);

    // R8 set wins over clear
    cyc(1'b0, 6'h3F, 16'h0, 1'b0, 1'b1, 8'h00);
    cyc(1'b1, 6'h14, 16'hFFFF, 1'b0, 1'b1, 8'h00);
    rdr(6'h14, v); chk("R8 set wins", v, 16'h0080);
    wr(6'h14, 16'hFFFF);

    // R9 interrupt masking per source
    for (int i = 0; i < 10; i++) begin
      int b;
      b = (i < 8) ? 8 + i : (i == 8 ? 7 : 4);
      wr(6'h18, 16'(1 << b));
      cyc(1'b0, 6'h3F, 16'h0, i == 9, i == 8, (i < 8) ? 8'(1 << i) : 8'h00);
      rdr(6'h14, v);
      chk("R9 irq own enable", {15'h0, irq}, 16'h1);
      wr(6'h18, ~16'(1 << b));
      rdr(6'h14, v);
      chk("R9 irq other enables", {15'h0, irq}, 16'h0);
      wr(6'h18, 16'(1 << b));
      wr(6'h14, 16'hFFFF);
      rdr(6'h14, v);
      chk("R9 irq after clear", {15'h0, irq}, 16'h0);
    end
    wr(6'h18, 16'h0000);

    // R10 alarm
    wr(6'h24, 16'd3); wr(6'h08, 16'h0A14); wr(6'h0C, 16'd30);
    set_time(64'd3 * 86400 + 10 * 3600 + 20 * 60 + 28);
    wr(6'h14, 16'hFFFF);
    wr(6'h10, 16'h0080);
    tick1(); rdr(6'h14, v); chk("R10 before match", v & 16'h0004, 16'h0);
    tick1(); rdr(6'h14, v); chk("R10 on match", v & 16'h0004, 16'h0004);
    wr(6'h18, 16'h0004); rdr(6'h14, v); chk("R10 R9 alarm irq", {15'h0, irq}, 16'h1);
    wr(6'h10, 16'h0000);
    wr(6'h14, 16'hFFFF);
    tick1(); rdr(6'h14, v); chk("R10 held no rematch", v & 16'h0004, 16'h0);
    wr(6'h04, 16'd30); rdr(6'h14, v); chk("R10 load no match", v & 16'h0004, 16'h0);
    chk_time("R10 time held", 64'd3 * 86400 + 10 * 3600 + 20 * 60 + 30);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule